// File: doc/BRIEF.md
# Dual-Source Latched Serializer

This block turns parallel pixel words into a serial bit stream. It holds a shift register whose width is set by a parameter, eight bits by default. On each rising clock edge the register does one of two things. It either loads a whole word or moves every bit one stage toward the output. The output always shows the top stage, so after a load the most significant bit of the word appears first.

The loaded word comes from one of two sources, chosen by a select input. Source A goes straight to the select logic. Source B first passes through a transparent latch. With this latch, the next B word can be captured while an A word is still being shifted out, so A and B words can be loaded in turn with no gap.

A serial input feeds the lowest stage. Several copies can be chained by connecting one copy's serial output to the next copy's serial input, which gives 16 bits or more. The path from stage to stage is one flop and one 2:1 choice, which keeps it short enough for a 100 MHz shift clock.

Top module: `mux_latch_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, every stage is cleared to 0, so `ser_out` reads 0 after that edge.
- R2: When `load_n` is 0 and `pick_a` is 1 at a rising edge, the register takes `a_word`, and `ser_out` then shows `a_word[WIDTH-1]`.
- R3: When `load_n` is 0 and `pick_a` is 0 at a rising edge, the register takes the word held by the B latch.
- R4: When `load_n` is 1 at a rising edge, stage i takes the old stage i-1 and stage 0 takes `ser_in`, so a loaded word comes out on `ser_out` most significant bit first, one bit per edge.
- R5: While `b_open` is 1, the B latch follows `b_word`, and a load from B takes the value that `b_word` has at that edge.
- R6: While `b_open` is 0, the B latch keeps the last value it had, whatever `b_word` does.
- R7: `pick_a` has no effect on a shift edge (`load_n` = 1).
- R8: Reset does not clear the B latch: a word captured before reset can still be loaded after it.
- R9: Two copies, with the lower copy's `ser_out` feeding the upper copy's `ser_in`, shift a 16-bit word out of the upper copy's `ser_out`: first the upper byte, then the lower byte, each most significant bit first.
- R10: Reset takes priority over a load that is asked for on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all register changes happen on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the register only |
| load_n | input | 1 | 0 = load the selected word on the edge, 1 = shift on the edge |
| pick_a | input | 1 | Source select for a load: 1 = A word, 0 = latched B word |
| b_open | input | 1 | B latch enable: 1 = the latch passes `b_word` through, 0 = it holds |
| a_word | input | WIDTH | Parallel word A, not latched |
| b_word | input | WIDTH | Parallel word B, goes through the latch |
| ser_in | input | 1 | Serial input into stage 0, used for chaining |
| ser_out | output | 1 | Serial output, the top stage |

## Verification
The bench checks interleaved loads in which B is captured and the latch is closed while A is loaded and shifted. It then changes `b_word` before the B load. A latch that stays open, or a select with its sense reversed, would send out the new `b_word` or the A word instead of the captured one. The bench also sets `load_n` low during reset, and it loads B after a reset. A design that lets the load win, or that clears the latch on reset, would show nonzero or zero bits in the wrong places on `ser_out`. The two-copy chain checks the bit order across the join. A shift in the wrong direction, or a serial input that enters the wrong stage, would scramble the 16-bit stream.

// File: rtl/serializer_pkg.sv
// Package: types shared by the serializer blocks.
// Assumes: the load control is active low at the block edge.
package serializer_pkg;

    // What a rising clock edge does to the register.
    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } edge_op_t;

    // Converts the active-low load pin into an edge operation.
    function automatic edge_op_t decode_op(input logic load_n);
        return load_n ? OP_SHIFT : OP_LOAD;
    endfunction

endpackage

// File: rtl/b_word_latch.sv
// Module: b_word_latch
// What it does: holds the B source word in a level-sensitive latch.
//   While open is 1 the output follows d; while open is 0 it keeps its value.
// Assumes: it has no reset. Its contents survive a reset of the register.
module b_word_latch #(
    parameter int WIDTH = 8
) (
    input  logic             open,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Transparent while open is high, holds while it is low.
    always_latch begin
        if (open) q <= d;
    end

endmodule

// File: rtl/word_select_mux.sv
// Module: word_select_mux
// What it does: picks the word to load, either the A word or the latched B word.
// Assumes: it is purely combinational, and only a load edge uses its output.
module word_select_mux #(
    parameter int WIDTH = 8
) (
    input  logic             pick_a,
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    output logic [WIDTH-1:0] y
);

    // 2:1 choice between the two sources.
    always_comb begin
        y = pick_a ? a_word : b_word;
    end

endmodule

// File: rtl/shift_chain.sv
// Module: shift_chain
// What it does: a register with one flop per stage. On a load edge it takes a
//   parallel word; on a shift edge it moves each bit up one stage and takes
//   ser_in into stage 0.
// Assumes: reset is synchronous and active low, and it wins over a load.
module shift_chain
    import serializer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edge_op_t         op,
    input  logic [WIDTH-1:0] par_d,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    // Serial feed for each stage: the stage below it, or ser_in for stage 0.
    logic [WIDTH-1:0] feed;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Stage 0 is fed from the serial input.
            always_comb feed[i] = ser_in;
        end else begin : g_upper
            // Every other stage is fed from the stage below it.
            always_comb feed[i] = q[i-1];
        end

        // One stage flop: clear on reset, otherwise load or shift.
        always_ff @(posedge clk) begin
            if (!rst_n)             q[i] <= 1'b0;
            else if (op == OP_LOAD) q[i] <= par_d[i];
            else                    q[i] <= feed[i];
        end
    end

endmodule

// File: rtl/mux_latch_serializer.sv
// Module: mux_latch_serializer (top)
// What it does: a parallel-in, serial-out register. The word it loads comes
//   from a 2:1 select between an A word and a latched B word. The top stage
//   drives ser_out, and ser_in feeds stage 0 so that copies can be chained.
// Assumes: every register change happens on the rising edge of clk; reset
//   clears the register and leaves the B latch as it is.
module mux_latch_serializer
    import serializer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             pick_a,
    input  logic             b_open,
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    input  logic             ser_in,
    output logic             ser_out
);

    logic [WIDTH-1:0] b_held;
    logic [WIDTH-1:0] load_word;
    logic [WIDTH-1:0] stage_q;
    edge_op_t         op;

    // Turns the load pin into an edge operation.
    always_comb op = decode_op(load_n);

    b_word_latch #(.WIDTH(WIDTH)) u_blatch (
        .open (b_open),
        .d    (b_word),
        .q    (b_held)
    );

    word_select_mux #(.WIDTH(WIDTH)) u_sel (
        .pick_a (pick_a),
        .a_word (a_word),
        .b_word (b_held),
        .y      (load_word)
    );

    shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_d  (load_word),
        .ser_in (ser_in),
        .q      (stage_q)
    );

    // The serial output is the top stage.
    always_comb ser_out = stage_q[WIDTH-1];

endmodule

// File: rtl/mux_latch_serializer_checker.sv
// Module: mux_latch_serializer_checker
// What it does: timing properties for the serializer, bound to the top.
// Assumes: WIDTH is at least 2.
module mux_latch_serializer_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             pick_a,
    input logic             b_open,
    input logic [WIDTH-1:0] a_word,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] b_held,
    input logic [WIDTH-1:0] stage_q
);

    // Set once at least one edge has passed with reset released.
    logic past_ok;

    // Tracks whether the previous cycle's values can be trusted.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: a reset edge leaves the register cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> stage_q == '0);

    // R2: loading A copies the A word.
    p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && pick_a) |=> stage_q == $past(a_word));

    // R3: loading B copies the latched word.
    p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !pick_a) |=> stage_q == $past(b_held));

    // R4: a shift brings the next-lower stage to the output.
    p_shift_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> ser_out == $past(stage_q[WIDTH-2]));

    // R9: a shift takes the serial input into stage 0.
    p_shift_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> stage_q[0] == $past(ser_in));

    // R6: a closed latch does not change.
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !b_open && !$past(b_open)) |-> $stable(b_held));

endmodule

bind mux_latch_serializer mux_latch_serializer_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .pick_a  (pick_a),
    .b_open  (b_open),
    .a_word  (a_word),
    .ser_in  (ser_in),
    .ser_out (ser_out),
    .b_held  (b_held),
    .stage_q (stage_q)
);

// File: tb/mux_latch_serializer_test.sv
// Bench: a single copy driven by directed and seeded random stimulus and
// checked against a reference model built from the requirements; then a
// two-copy chain.
module mux_latch_serializer_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, load_n, pick_a, b_open, ser_in;
    logic [W-1:0] a_word, b_word;
    logic         ser_out;

    // Inputs and outputs of the two-copy chain.
    logic         c_rst_n, c_load_n;
    logic [W-1:0] lo_a, hi_a;
    logic         lo_out, hi_out;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    logic [W-1:0] m_reg;
    logic [W-1:0] m_latch;

    always #2 clk = ~clk;   // 250 MHz

    mux_latch_serializer #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .pick_a(pick_a),
        .b_open(b_open), .a_word(a_word), .b_word(b_word),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    mux_latch_serializer #(.WIDTH(W)) u_lo (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .pick_a(1'b1),
        .b_open(1'b0), .a_word(lo_a), .b_word('0),
        .ser_in(1'b0), .ser_out(lo_out)
    );

    mux_latch_serializer #(.WIDTH(W)) u_hi (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .pick_a(1'b1),
        .b_open(1'b0), .a_word(hi_a), .b_word('0),
        .ser_in(lo_out), .ser_out(hi_out)
    );

    // Counts one check and reports it if it fails.
    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ser_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Next register value, worked out from the requirements.
    function automatic logic [W-1:0] model_next(
        input logic r, input logic ld, input logic pa,
        input logic [W-1:0] a, input logic [W-1:0] bl,
        input logic [W-1:0] cur, input logic si);
        if (!r)       return '0;
        else if (!ld) return pa ? a : bl;
        else          return {cur[W-2:0], si};
    endfunction

    // One clock cycle: drive inputs away from the edge, update the model, check.
    task automatic step(input string tag, input logic r, input logic ld,
                        input logic pa, input logic le, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic si);
        @(negedge clk);
        rst_n = r; load_n = ld; pick_a = pa; b_open = le;
        a_word = a; b_word = b; ser_in = si;
        if (le) m_latch = b;
        @(posedge clk);
        m_reg = model_next(r, ld, pa, a, m_latch, m_reg, si);
        #1;
        check(tag, ser_out, m_reg[W-1]);
    endtask

    // Shifts n times with the serial input at 0 and the latch closed.
    task automatic drain(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, 1'($urandom), 0, 8'h00, 8'($urandom), 0);
    endtask

    initial begin
        logic [2*W-1:0] exp16;
        void'($urandom(32'd1357));
        m_reg = '0; m_latch = '0;
        c_rst_n = 1'b0; c_load_n = 1'b1; lo_a = '0; hi_a = '0;

        // R1: reset state; the latch is open so that it starts with a known value.
        step("R1", 0, 1, 0, 1, 8'h00, 8'h00, 1);
        step("R1", 0, 1, 0, 1, 8'h00, 8'h00, 1);
        drain("R1", W - 1);

        // R2: load A = 8'hA5 and read it out MSB first (R4).
        step("R2", 1, 0, 1, 0, 8'hA5, 8'h00, 0);
        drain("R4", W - 1);

        // R5: open latch, load B = 8'h3C on the same edge.
        step("R5", 1, 0, 0, 1, 8'h00, 8'h3C, 0);
        drain("R4", W - 1);

        // R6: capture B = 8'hC3, close, load and shift A, then load B while b_word changes.
        step("R6", 1, 1, 0, 1, 8'h00, 8'hC3, 0);
        step("R2", 1, 0, 1, 0, 8'h96, 8'h5A, 0);
        drain("R6", W - 1);
        step("R3", 1, 0, 0, 0, 8'hFF, 8'h0F, 0);
        drain("R3", W - 1);

        // R7: pick_a toggles on shift edges while ones shift in.
        step("R2", 1, 0, 1, 0, 8'h81, 8'h00, 1);
        for (int i = 0; i < W; i++) step("R7", 1, 1, i[0], 0, 8'h00, 8'hEE, 1);

        // R10: reset with a load asked for on the same edge.
        step("R10", 0, 0, 1, 0, 8'hFF, 8'h00, 1);
        drain("R10", W - 1);

        // R8: the latch still holds 8'hC3 after reset.
        step("R8", 1, 0, 0, 0, 8'h00, 8'h11, 0);
        drain("R8", W - 1);

        // Random mix; the tag follows what the edge does.
        for (int i = 0; i < 600; i++) begin
            logic r, ld, pa, le;
            string t;
            r  = ($urandom_range(0, 31) != 0);
            ld = ($urandom_range(0, 3) != 0);
            pa = 1'($urandom);
            le = 1'($urandom);
            if (!r)      t = "R1";
            else if (ld) t = "R4";
            else if (pa) t = "R2";
            else         t = le ? "R5" : "R6";
            step(t, r, ld, pa, le, 8'($urandom), 8'($urandom), 1'($urandom));
        end

        // R9: 16-bit chain; the upper byte comes out first, then the lower byte.
        lo_a = 8'h4D; hi_a = 8'hB2;
        exp16 = {hi_a, lo_a};
        @(negedge clk); c_rst_n = 1'b0;
        @(negedge clk); c_rst_n = 1'b1; c_load_n = 1'b0;
        @(negedge clk); c_load_n = 1'b1;
        check("R9", hi_out, exp16[2*W-1]);
        for (int i = 1; i < 2 * W; i++) begin
            @(negedge clk);
            check("R9", hi_out, exp16[2*W-1-i]);
        end
        @(negedge clk);
        check("R9", hi_out, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule